// File: doc/BRIEF.md
# Byte-Oriented Synchronous Serial Port

This block is a full-duplex synchronous serial port that moves bytes on a serial wire while the host exchanges 16-bit words with it through a small register interface. A host write to the data address queues one 16-bit word (two wire bytes) into a transmit FIFO. A host read from the data address takes one assembled 16-bit word (two received bytes) from a receive FIFO. How the two bytes of a word map onto a byte stream is left to software.

The port works as clock master or as slave. As master it divides the system clock to make the serial clock and raises a frame-select output for as long as words are waiting or being shifted. As slave it follows an external serial clock and frame-select. When an external frame ends after an odd number of bytes, the single trailing byte is left in the receive shifter and two status flags report it. A write to a separate pop address then moves that byte into the receive FIFO so the host can read it.

Top module: `byte_ssp`

## Requirements
- R1: A write to address 0 queues only bits 15:0 of the written data into the TX FIFO. Bits 31:16 are ignored.
- R2: A read of address 0 returns the oldest RX FIFO word in bits 15:0 and removes it. Bits 31:16 read as zero. A read from an empty RX FIFO returns all zeros.
- R3: The TX FIFO holds FIFO_DEPTH words. A write while it is full is dropped. Status bit 2 shows TX full.
- R4: In master mode a data write starts a frame. fs_o stays high while the TX FIFO or the shifter holds data, so back-to-back words share one frame. fs_o drops after the last word.
- R5: In master mode sclk_o idles low and has a period of 2*CLK_HALF system clocks. sdo changes on the falling sclk edge and sdi is sampled on the rising edge.
- R6: Each word is shifted with the high byte first and each byte MSB first. Received bits are assembled in the same order, so a loopback returns the word that was sent.
- R7: The port is full duplex. Every 16 received bits push one RX FIFO word while the TX word shifts out. A push to a full RX FIFO is dropped. When the TX FIFO is empty in slave mode, zeros are sent.
- R8: In slave mode a frame starts on a rising fs_i and the port shifts on sclk_i edges. fs_o and sclk_o stay low.
- R9: If fs_i falls while exactly 8 bits of the current word have been received, status bit 0 (residual valid) and bit 1 (residual frame) are set.
- R10: A write to address 1 pushes the receive shifter into the RX FIFO, with the residual byte in bits 7:0 and zeros above. It clears residual valid. The written value is ignored.
- R11: Residual frame stays set after a pop and clears when the next frame starts.
- R12: A read of address 2 returns status: bit 0 residual valid, bit 1 residual frame, bit 2 TX full, bit 3 RX empty, all other bits zero. After reset it reads 0x8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1 = clock master, 0 = slave |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | 0 data, 1 pop, 2 status |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational) |
| sclk_o | output | 1 | Serial clock out (master) |
| sclk_i | input | 1 | Serial clock in (slave) |
| fs_o | output | 1 | Frame select out (master) |
| fs_i | input | 1 | Frame select in (slave) |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The bench builds the port with FIFO_DEPTH = 4 and CLK_HALF = 2. The shallow FIFO lets a handful of writes hit the TX-full drop. It also lets one five-word slave frame show both the zero fill after the TX FIFO drains and the drop of a push into a full RX FIFO. The short divider keeps master loopback frames at a few hundred cycles, so the serial clock period can be timed on every edge. Slave frames use a slow external clock with 8 system cycles per phase, which covers the input synchronizers and the residual-byte path.

// File: rtl/bssp_pkg.sv
package bssp_pkg;

    localparam int unsigned WORD_W = 16;

    typedef enum logic [1:0] {
        A_DATA = 2'd0,
        A_POP  = 2'd1,
        A_STAT = 2'd2
    } bssp_addr_e;

    // packed from bit 3 down to bit 0
    typedef struct packed {
        logic rx_empty;
        logic tx_full;
        logic res_frame;
        logic res_valid;
    } bssp_stat_t;

    function automatic logic [31:0] stat_word(bssp_stat_t s);
        return {28'd0, s};
    endfunction

    function automatic logic [31:0] data_word(logic [WORD_W-1:0] d);
        return {{(32-WORD_W){1'b0}}, d};
    endfunction

endpackage

// File: rtl/bssp_fifo.sv
module bssp_fifo #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic          empty,
    output logic [LW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/bssp_clkgen.sv
module bssp_clkgen #(
    parameter int unsigned CLK_HALF = 4,
    localparam int unsigned CW      = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic master,
    input  logic run,
    input  logic sclk_i,
    input  logic fs_i,
    output logic sclk_o,
    output logic rise,
    output logic fall,
    output logic fs_s
);
    logic [CW-1:0] cnt;
    logic          sclk_q;
    logic [2:0]    sc_sync;
    logic [1:0]    fs_sync;
    logic          m_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            sclk_q  <= 1'b0;
            sc_sync <= '0;
            fs_sync <= '0;
        end else begin
            sc_sync <= {sc_sync[1:0], sclk_i};
            fs_sync <= {fs_sync[0], fs_i};
            if (master && run) begin
                if (m_tick) begin
                    cnt    <= '0;
                    sclk_q <= ~sclk_q;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt    <= '0;
                sclk_q <= 1'b0;
            end
        end
    end

    assign m_tick = master && run && (cnt == CW'(CLK_HALF - 1));
    assign rise   = master ? (m_tick && !sclk_q) : (sc_sync[1] && !sc_sync[2]);
    assign fall   = master ? (m_tick && sclk_q)  : (!sc_sync[1] && sc_sync[2]);
    assign fs_s   = fs_sync[1];
    assign sclk_o = sclk_q && master;
endmodule

// File: rtl/bssp_engine.sv
module bssp_engine
    import bssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              master,
    input  logic              rise,
    input  logic              fall,
    input  logic              fs_s,
    input  logic              sdi,
    input  logic              tx_avail,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              pop_req,
    output logic              tx_take,
    output logic              active,
    output logic              sdo,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word,
    output logic              res_valid,
    output logic              res_frame
);
    localparam int unsigned BW = $clog2(WORD_W);

    logic              last, fs_q;
    logic [BW-1:0]     bit_cnt;
    logic [WORD_W-1:0] tx_sh, rx_sh;
    logic              fs_rise, fs_fall, m_start, word_end, next_load;

    assign fs_rise   = !master && fs_s && !fs_q;
    assign fs_fall   = !master && !fs_s && fs_q;
    assign m_start   = master && !active && tx_avail;
    assign word_end  = active && rise && (bit_cnt == BW'(WORD_W - 1));
    assign next_load = active && fall && last;
    assign tx_take   = m_start || (fs_rise && tx_avail) || (next_load && tx_avail);
    assign rx_push   = word_end || pop_req;
    assign rx_word   = word_end ? {rx_sh[WORD_W-2:0], sdi} : rx_sh;
    assign sdo       = tx_sh[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            last      <= 1'b0;
            fs_q      <= 1'b0;
            bit_cnt   <= '0;
            tx_sh     <= '0;
            rx_sh     <= '0;
            res_valid <= 1'b0;
            res_frame <= 1'b0;
        end else begin
            fs_q <= fs_s;
            if (m_start || fs_rise) begin
                active    <= 1'b1;
                last      <= 1'b0;
                bit_cnt   <= '0;
                rx_sh     <= '0;
                tx_sh     <= tx_avail ? tx_word : '0;
                res_frame <= 1'b0;
            end else if (fs_fall && active) begin
                active <= 1'b0;
                if (bit_cnt == BW'(8)) begin
                    res_valid <= 1'b1;
                    res_frame <= 1'b1;
                end
            end else if (active) begin
                if (rise) begin
                    bit_cnt <= bit_cnt + 1'b1;
                    if (word_end) begin
                        rx_sh <= '0;
                        last  <= 1'b1;
                    end else begin
                        rx_sh <= {rx_sh[WORD_W-2:0], sdi};
                    end
                end
                if (fall) begin
                    if (last) begin
                        last  <= 1'b0;
                        tx_sh <= tx_avail ? tx_word : '0;
                        if (master && !tx_avail) active <= 1'b0;
                    end else begin
                        tx_sh <= tx_sh << 1;
                    end
                end
            end
            if (pop_req) begin
                res_valid <= 1'b0;
                if (!word_end) begin
                    rx_sh   <= '0;
                    bit_cnt <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/byte_ssp.sv
module byte_ssp
    import bssp_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 16,
    parameter int unsigned CLK_HALF   = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_master,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [1:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        sclk_o,
    input  logic        sclk_i,
    output logic        fs_o,
    input  logic        fs_i,
    output logic        sdo,
    input  logic        sdi
);
    localparam int unsigned LVL_W = $clog2(FIFO_DEPTH + 1);

    bssp_addr_e        addr;
    logic              wr_data, rd_data, pop_req;
    logic              tx_full, tx_empty, rx_full, rx_empty, tx_take;
    logic [LVL_W-1:0]  tx_level, rx_level;
    logic [WORD_W-1:0] tx_head, rx_head, rx_word;
    logic              rx_push, active, res_valid, res_frame;
    logic              rise, fall, fs_s;
    logic              unused_hi;
    bssp_stat_t        stat;

    assign addr      = bssp_addr_e'(host_addr);
    assign wr_data   = host_wr && (addr == A_DATA);
    assign rd_data   = host_rd && (addr == A_DATA);
    assign pop_req   = host_wr && (addr == A_POP);
    assign unused_hi = ^{host_wdata[31:16], rx_full, rx_level};

    bssp_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .push(wr_data), .din(host_wdata[WORD_W-1:0]),
        .pop(tx_take), .dout(tx_head), .full(tx_full), .empty(tx_empty),
        .level(tx_level)
    );

    bssp_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .push(rx_push), .din(rx_word),
        .pop(rd_data), .dout(rx_head), .full(rx_full), .empty(rx_empty),
        .level(rx_level)
    );

    bssp_clkgen #(.CLK_HALF(CLK_HALF)) u_clk (
        .clk(clk), .rst(rst), .master(cfg_master), .run(active),
        .sclk_i(sclk_i), .fs_i(fs_i), .sclk_o(sclk_o),
        .rise(rise), .fall(fall), .fs_s(fs_s)
    );

    bssp_engine u_eng (
        .clk(clk), .rst(rst), .master(cfg_master), .rise(rise), .fall(fall),
        .fs_s(fs_s), .sdi(sdi), .tx_avail(!tx_empty), .tx_word(tx_head),
        .pop_req(pop_req), .tx_take(tx_take), .active(active), .sdo(sdo),
        .rx_push(rx_push), .rx_word(rx_word),
        .res_valid(res_valid), .res_frame(res_frame)
    );

    assign fs_o = cfg_master && active;

    always_comb begin
        stat.rx_empty  = rx_empty;
        stat.tx_full   = tx_full;
        stat.res_frame = res_frame;
        stat.res_valid = res_valid;
        case (addr)
            A_DATA:  host_rdata = rx_empty ? 32'd0 : data_word(rx_head);
            A_STAT:  host_rdata = stat_word(stat);
            default: host_rdata = 32'd0;
        endcase
    end
endmodule

// File: rtl/byte_ssp_chk.sv
module byte_ssp_chk #(
    parameter int unsigned LVL_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_master,
    input logic             fs_o,
    input logic             sclk_o,
    input logic             host_wr,
    input logic             host_rd,
    input logic [1:0]       host_addr,
    input logic [31:0]      host_rdata,
    input logic             rx_empty,
    input logic             tx_full,
    input logic             tx_take,
    input logic [LVL_W-1:0] tx_level,
    input logic             res_valid
);
    p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr == 2'd0) |-> (host_rdata[31:16] == 16'd0));

    p_empty_read_r2: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr == 2'd0 && rx_empty) |-> (host_rdata == 32'd0));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_full && host_wr && host_addr == 2'd0 && !tx_take) |=> (tx_level == $past(tx_level)));

    p_sclk_in_frame_r4: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> fs_o);

    p_slave_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !cfg_master |-> (!fs_o && !sclk_o));

    p_pop_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == 2'd1) |=> !res_valid);
endmodule

bind byte_ssp byte_ssp_chk #(.LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst(rst), .cfg_master(cfg_master), .fs_o(fs_o), .sclk_o(sclk_o),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_rdata(host_rdata), .rx_empty(rx_empty), .tx_full(tx_full),
    .tx_take(tx_take), .tx_level(tx_level), .res_valid(res_valid)
);

// File: tb/byte_ssp_tb_top.sv
module byte_ssp_tb_top;
    localparam int DEPTH = 4;
    localparam int HALF  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_master = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [31:0] host_wdata = 32'd0;
    logic [31:0] host_rdata;
    logic        sclk_o, fs_o, sdo;
    logic        sclk_i = 1'b0, fs_i = 1'b0, sdi_drv = 1'b0, loop = 1'b0;
    logic        sdi_w;

    int errors = 0, checks = 0;
    bit done = 0;

    logic [63:0] cap_bits;
    int  cap_n = 0;
    bit  per_bad = 0;
    time last_t = 0;
    int  fs_falls = 0;
    bit  slave_noise = 0;

    always #5 clk = ~clk;
    assign sdi_w = loop ? sdo : sdi_drv;

    byte_ssp #(.FIFO_DEPTH(DEPTH), .CLK_HALF(HALF)) dut_i (
        .clk(clk), .rst(rst), .cfg_master(cfg_master),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sclk_o(sclk_o), .sclk_i(sclk_i), .fs_o(fs_o), .fs_i(fs_i),
        .sdo(sdo), .sdi(sdi_w)
    );

    always @(posedge sclk_o) begin
        cap_bits = {cap_bits[62:0], sdo};
        if (cap_n > 0 && ($time - last_t) != 40) per_bad = 1;
        last_t = $time;
        cap_n++;
    end
    always @(negedge fs_o) fs_falls++;
    always @(negedge clk) if (!rst && !cfg_master && (fs_o || sclk_o)) slave_noise = 1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic slave_xfer(input int nbits, input logic [79:0] mosi, output logic [79:0] miso);
        miso = '0;
        fs_i = 1'b1;
        repeat (8) @(negedge clk);
        for (int i = nbits - 1; i >= 0; i--) begin
            sdi_drv = mosi[i];
            repeat (8) @(negedge clk);
            miso[i] = sdo;
            sclk_i = 1'b1;
            repeat (8) @(negedge clk);
            sclk_i = 1'b0;
        end
        repeat (8) @(negedge clk);
        fs_i = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check(fs_o == 1'b0 && sclk_o == 1'b0, "R12 reset serial outputs", {30'd0, fs_o, sclk_o}, 32'd0);
        host_read(2'd2, d);
        check(d == 32'h8, "R12 reset status", d, 32'h8);
        host_read(2'd0, d);
        check(d == 32'h0, "R2 empty read", d, 32'h0);
    endtask

    task automatic t_master_loop;
        logic [31:0] d;
        int n;
        cfg_master = 1'b1; loop = 1'b1;
        cap_n = 0; per_bad = 0; fs_falls = 0;
        host_write(2'd0, 32'hFFFF_A5C3);
        host_write(2'd0, 32'h0000_1E7F);
        check(fs_o == 1'b1, "R4 frame starts on write", {31'd0, fs_o}, 32'd1);
        n = 0;
        while (fs_o && n < 2000) begin @(negedge clk); n++; end
        repeat (4) @(negedge clk);
        check(fs_falls == 1, "R4 one frame for two words", fs_falls, 1);
        check(cap_n == 32, "R5 sclk edge count", cap_n, 32);
        check(!per_bad, "R5 sclk period", {31'd0, per_bad}, 32'd0);
        check(cap_bits[31:0] == 32'hA5C3_1E7F, "R6 R1 wire bit order", cap_bits[31:0], 32'hA5C3_1E7F);
        host_read(2'd0, d);
        check(d == 32'h0000_A5C3, "R7 R6 loopback word 1", d, 32'h0000_A5C3);
        host_read(2'd0, d);
        check(d == 32'h0000_1E7F, "R7 R6 loopback word 2", d, 32'h0000_1E7F);
        host_read(2'd2, d);
        check(d == 32'h8, "R12 status after drain", d, 32'h8);
        cfg_master = 1'b0; loop = 1'b0;
    endtask

    task automatic t_full_drop;
        logic [31:0] d;
        logic [79:0] miso;
        host_write(2'd0, 32'hDEAD_1111);
        host_write(2'd0, 32'h0000_2222);
        host_write(2'd0, 32'h7777_3333);
        host_write(2'd0, 32'h0000_4444);
        host_write(2'd0, 32'h0000_5555);
        host_read(2'd2, d);
        check(d[2] == 1'b1, "R3 tx full flag", d, 32'h4);
        slave_xfer(80, 80'h9001_9002_9003_9004_9005, miso);
        check(miso == 80'h1111_2222_3333_4444_0000, "R3 R7 R1 slave tx stream",
              miso[31:0], 32'h4444_0000);
        check(miso[79:48] == 32'h1111_2222, "R7 slave tx high words", miso[79:48], 32'h1111_2222);
        host_read(2'd0, d); check(d == 32'h9001, "R7 rx word 1", d, 32'h9001);
        host_read(2'd0, d); check(d == 32'h9002, "R7 rx word 2", d, 32'h9002);
        host_read(2'd0, d); check(d == 32'h9003, "R7 rx word 3", d, 32'h9003);
        host_read(2'd0, d); check(d == 32'h9004, "R7 rx word 4", d, 32'h9004);
        host_read(2'd0, d); check(d == 32'h0, "R7 R2 rx overflow dropped", d, 32'h0);
    endtask

    task automatic t_residual;
        logic [31:0] d;
        logic [79:0] miso;
        slave_xfer(24, 80'h00C0_DE5A, miso);
        check(miso[23:0] == 24'h0, "R7 zero fill when tx empty", miso[31:0], 32'h0);
        host_read(2'd2, d);
        check(d == 32'h3, "R9 residual flags", d, 32'h3);
        host_read(2'd0, d);
        check(d == 32'h0000_C0DE, "R9 full word before residual", d, 32'h0000_C0DE);
        host_write(2'd1, 32'hFFFF_FFFF);
        host_read(2'd2, d);
        check(d == 32'h2, "R10 R11 pop clears valid only", d, 32'h2);
        host_read(2'd0, d);
        check(d == 32'h0000_005A, "R10 residual in low byte", d, 32'h0000_005A);
        slave_xfer(16, 80'h1234, miso);
        host_read(2'd2, d);
        check(d == 32'h0, "R11 new frame clears residual frame", d, 32'h0);
        host_read(2'd0, d);
        check(d == 32'h1234, "R8 slave word", d, 32'h1234);
        check(!slave_noise, "R8 fs_o sclk_o quiet in slave", {31'd0, slave_noise}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset;
        t_master_loop;
        t_full_drop;
        t_residual;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule